// File: doc/BRIEF.md
# Write Leveling Delay Search

This block is the host-side controller that aligns the data strobe with the memory clock at the device pins. On a start request it sends a mode-register write that puts the device into its leveling mode. It then waits a programmable settling time and runs a series of trials. Each trial launches one strobe pulse, waits a second programmable time for the device to return the clock level it captured at that strobe edge on a data line, and then samples that feedback.

A trial fails when the feedback is low. The controller then advances the strobe delay tap by one step and runs the next trial. The search stops at the first tap that returns a high level. It also stops once the highest tap has failed. In both cases the controller sends a second mode-register write that takes the device out of leveling mode, and then reports completion. The chosen tap stays on the delay output for the delay line to use.

The feedback line can be noisy while the clock edge sits close to the strobe. For that reason a trial passes only when two consecutive samples read high.

Top module: `wl_search`

## Requirements
- R1: A start request accepted while idle raises `mrw_req_o` with `mrw_enter_o`=1. The request and its direction stay unchanged until `mrw_ack_i` is seen. No strobe is launched before that acknowledge.
- R2: The first strobe comes exactly max(`wlmrd_cyc_i`,1)+1 cycles after the cycle in which the enter acknowledge is high.
- R3: Each strobe is a single-cycle pulse on `strobe_o`. The feedback is sampled only on the two cycles that follow max(`wlo_cyc_i`,1) wait cycles after the strobe cycle.
- R4: The tap is 0 for the first trial of every search and is unchanged from a strobe until that trial's samples are taken. The n-th strobe of a search (counting from 0) is launched with tap n.
- R5: A trial passes only when both samples are 1. A 0 on any sample fails the trial at once. The tap then rises by one and the next strobe follows in the next cycle.
- R6: On a passing trial the search ends with `fail_o`=0, and `tap_o` holds the passing tap until the next accepted start.
- R7: When the trial at the highest tap (127 at default width) fails, the search ends with `fail_o`=1 and `tap_o`=127. Both stay until the next accepted start, which clears `fail_o`.
- R8: At the end of every search `mrw_req_o` is raised with `mrw_enter_o`=0. `done_o` is then high for exactly one cycle, in the cycle after the exit acknowledge.
- R9: `start_i` is ignored from the cycle the start is accepted up to and including the `done_o` cycle. No second enter request follows from it.
- R10: In reset, `mrw_req_o`, `strobe_o`, `done_o` and `fail_o` are 0 and `tap_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a search (taken only when idle) |
| wlmrd_cyc_i | input | CNT_W | Wait after leveling-mode entry, in cycles (0 acts as 1) |
| wlo_cyc_i | input | CNT_W | Wait from strobe to first sample, in cycles (0 acts as 1) |
| mrw_req_o | output | 1 | Mode-register write request, held until acknowledged |
| mrw_enter_o | output | 1 | 1 = enter leveling mode, 0 = leave it; valid with the request |
| mrw_ack_i | input | 1 | Mode-register write accepted |
| strobe_o | output | 1 | One-cycle strobe launch |
| fb_i | input | 1 | Clock level returned by the device |
| tap_o | output | TAP_W | Strobe delay tap |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | No passing tap was found |

## Verification
Two decisions can fall in the same cycle. The first pair is the failing sample at the highest tap and the tap-advance decision. This is provoked with a device model that never passes and that also returns a single high glitch sample at tap 127. The bench judges that no wrap to 0 and no extra strobe occur, that `fail_o` rises, and that 128 strobes are seen in total. The second pair is a new `start_i` and the completion pulse. The bench raises start in exactly the `done_o` cycle and also in the middle of a search. It then counts enter requests over the following cycles and expects no new one.

// File: rtl/wl_pkg.sv
package wl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ENTER,
    ST_MRD,
    ST_STROBE,
    ST_WLO,
    ST_SAMPLE,
    ST_EXIT,
    ST_DONE
  } wl_state_e;
endpackage

// File: rtl/wl_wait_timer.sv
module wl_wait_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  // Loaded value N gives max(N,1) cycles until expiry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (load_i)                   cnt_q <= load_val_i;
    else if (cnt_q > CNT_W'(1))        cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expired_o = (cnt_q <= CNT_W'(1)) && !load_i;
endmodule

// File: rtl/wl_pass_filter.sv
module wl_pass_filter #(
  parameter int PASS_CNT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic sample_i,
  input  logic bit_i,
  output logic pass_o,
  output logic miss_o
);
  localparam int RUN_W = $clog2(PASS_CNT + 1);
  localparam logic [RUN_W-1:0] LAST = RUN_W'(PASS_CNT - 1);

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     run_q <= '0;
    else if (clear_i || miss_o)      run_q <= '0;
    else if (sample_i && bit_i)      run_q <= run_q + RUN_W'(1);
  end

  assign pass_o = sample_i && bit_i && (run_q == LAST);
  assign miss_o = sample_i && !bit_i;
endmodule

// File: rtl/wl_tap_ctr.sv
module wl_tap_ctr #(
  parameter int TAP_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [TAP_W-1:0] tap_o,
  output logic             at_max_o
);
  localparam logic [TAP_W-1:0] TAP_MAX = {TAP_W{1'b1}};

  logic [TAP_W-1:0] tap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  tap_q <= '0;
    else if (clr_i)               tap_q <= '0;
    else if (inc_i && !at_max_o)  tap_q <= tap_q + TAP_W'(1);
  end

  assign tap_o    = tap_q;
  assign at_max_o = (tap_q == TAP_MAX);
endmodule

// File: rtl/wl_search.sv
module wl_search
  import wl_pkg::*;
#(
  parameter int TAP_W    = 7,
  parameter int CNT_W    = 8,
  parameter int PASS_CNT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] wlmrd_cyc_i,
  input  logic [CNT_W-1:0] wlo_cyc_i,
  output logic             mrw_req_o,
  output logic             mrw_enter_o,
  input  logic             mrw_ack_i,
  output logic             strobe_o,
  input  logic             fb_i,
  output logic [TAP_W-1:0] tap_o,
  output logic             done_o,
  output logic             fail_o
);
  wl_state_e state_q, state_d;

  logic             tmr_load, tmr_exp;
  logic [CNT_W-1:0] tmr_val;
  logic             flt_clear, flt_sample, flt_pass, flt_miss;
  logic             tap_clr, tap_inc, tap_max;
  logic             fail_q, fail_set, start_acc;

  wl_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_exp)
  );

  wl_pass_filter #(.PASS_CNT(PASS_CNT)) u_filter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (flt_clear),
    .sample_i (flt_sample),
    .bit_i    (fb_i),
    .pass_o   (flt_pass),
    .miss_o   (flt_miss)
  );

  wl_tap_ctr #(.TAP_W(TAP_W)) u_tap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (tap_clr),
    .inc_i    (tap_inc),
    .tap_o    (tap_o),
    .at_max_o (tap_max)
  );

  always_comb begin
    state_d    = state_q;
    tmr_load   = 1'b0;
    tmr_val    = wlo_cyc_i;
    flt_clear  = 1'b0;
    flt_sample = 1'b0;
    tap_clr    = 1'b0;
    tap_inc    = 1'b0;
    fail_set   = 1'b0;
    start_acc  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        start_acc = 1'b1;
        tap_clr   = 1'b1;
        state_d   = ST_ENTER;
      end
      ST_ENTER: if (mrw_ack_i) begin
        tmr_load = 1'b1;
        tmr_val  = wlmrd_cyc_i;
        state_d  = ST_MRD;
      end
      ST_MRD: if (tmr_exp) state_d = ST_STROBE;
      ST_STROBE: begin
        tmr_load  = 1'b1;
        flt_clear = 1'b1;
        state_d   = ST_WLO;
      end
      ST_WLO: if (tmr_exp) state_d = ST_SAMPLE;
      ST_SAMPLE: begin
        flt_sample = 1'b1;
        if (flt_pass) state_d = ST_EXIT;
        else if (flt_miss) begin
          if (tap_max) begin
            fail_set = 1'b1;
            state_d  = ST_EXIT;
          end else begin
            tap_inc = 1'b1;
            state_d = ST_STROBE;
          end
        end
      end
      ST_EXIT: if (mrw_ack_i) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_acc)     fail_q <= 1'b0;
      else if (fail_set) fail_q <= 1'b1;
    end
  end

  assign mrw_req_o   = (state_q == ST_ENTER) || (state_q == ST_EXIT);
  assign mrw_enter_o = (state_q == ST_ENTER);
  assign strobe_o    = (state_q == ST_STROBE);
  assign done_o      = (state_q == ST_DONE);
  assign fail_o      = fail_q;
endmodule

// File: rtl/wl_search_chk.sv
module wl_search_chk #(
  parameter int TAP_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mrw_req_o,
  input logic             mrw_enter_o,
  input logic             mrw_ack_i,
  input logic             strobe_o,
  input logic [TAP_W-1:0] tap_o,
  input logic             done_o,
  input logic             fail_o
);
  assert_mrw_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mrw_req_o && !mrw_ack_i) |=> (mrw_req_o && $stable(mrw_enter_o)));

  assert_strobe_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);

  assert_tap_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> $stable(tap_o));

  assert_fail_tap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (tap_o == {TAP_W{1'b1}}));

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_after_exit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(mrw_req_o) && !$past(mrw_enter_o) && $past(mrw_ack_i)));

  always_comb begin
    if (!rst_ni) begin
      assert_reset_quiet_R10: assert (!mrw_req_o && !strobe_o && !done_o && !fail_o);
    end
  end
endmodule

bind wl_search wl_search_chk #(.TAP_W(TAP_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mrw_req_o   (mrw_req_o),
  .mrw_enter_o (mrw_enter_o),
  .mrw_ack_i   (mrw_ack_i),
  .strobe_o    (strobe_o),
  .tap_o       (tap_o),
  .done_o      (done_o),
  .fail_o      (fail_o)
);

// File: tb/wl_search_tb.sv
module wl_search_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ACK_DLY    = 3;
  localparam int NVEC       = 5;
  localparam int WDOG       = 150000;

  // {wlmrd, wlo, thresh, glitch_tap, exp_tap, exp_fail}
  localparam logic [7:0] VEC [NVEC][6] = '{
    '{8'd4, 8'd3, 8'd5,   8'd255, 8'd5,   8'd0},
    '{8'd0, 8'd0, 8'd0,   8'd255, 8'd0,   8'd0},
    '{8'd9, 8'd2, 8'd10,  8'd6,   8'd10,  8'd0},
    '{8'd1, 8'd1, 8'd128, 8'd127, 8'd127, 8'd1},
    '{8'd3, 8'd5, 8'd127, 8'd255, 8'd127, 8'd0}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] wlmrd_cyc_i = '0;
  logic [7:0] wlo_cyc_i = '0;
  logic       mrw_req_o, mrw_enter_o, strobe_o, done_o, fail_o;
  logic       mrw_ack_i = 1'b0;
  logic       fb_i = 1'b0;
  logic [6:0] tap_o;

  int tests = 0, fails = 0;
  int cyc = 0, req_age = 0, k = 0;
  int thresh = 255, gtap = 255;
  int enter_ack_cyc, exit_ack_cyc, first_strobe_cyc, done_cyc;
  int strobe_cnt, seq_err, early_err, enter_reqs;
  logic prev_enter_req = 1'b0;

  wl_search u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .wlmrd_cyc_i(wlmrd_cyc_i), .wlo_cyc_i(wlo_cyc_i),
    .mrw_req_o(mrw_req_o), .mrw_enter_o(mrw_enter_o), .mrw_ack_i(mrw_ack_i),
    .strobe_o(strobe_o), .fb_i(fb_i), .tap_o(tap_o),
    .done_o(done_o), .fail_o(fail_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    enter_ack_cyc = -1; exit_ack_cyc = -1; first_strobe_cyc = -1; done_cyc = -1;
    strobe_cnt = 0; seq_err = 0; early_err = 0; enter_reqs = 0;
  endtask

  // Device and monitor model, evaluated mid-cycle
  always @(negedge clk_i) begin
    int weff;
    logic lvl, win, glitch;
    cyc++;
    if (cyc > WDOG) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
    if (mrw_ack_i) begin
      mrw_ack_i = 1'b0;
      req_age = 0;
    end else if (mrw_req_o) begin
      req_age++;
      if (req_age == ACK_DLY) begin
        mrw_ack_i = 1'b1;
        if (mrw_enter_o) enter_ack_cyc = cyc; else exit_ack_cyc = cyc;
      end
    end else req_age = 0;
    if (mrw_req_o && mrw_enter_o && !prev_enter_req) enter_reqs++;
    prev_enter_req = mrw_req_o && mrw_enter_o;
    if (strobe_o) begin
      if (first_strobe_cyc < 0) first_strobe_cyc = cyc;
      if (int'(tap_o) != strobe_cnt) seq_err++;
      if (enter_ack_cyc < 0) early_err++;
      strobe_cnt++;
      k = 0;
    end else k++;
    if (done_o) done_cyc = cyc;
    weff   = (wlo_cyc_i == 0) ? 1 : int'(wlo_cyc_i);
    lvl    = (int'(tap_o) >= thresh);
    win    = (k == weff + 1) || (k == weff + 2);
    glitch = (int'(tap_o) == gtap) && (k == weff + 1);
    fb_i   = win ? (lvl || glitch) : !lvl;
  end

  task automatic run_vec(input int i, input logic mid_start, input logic start_at_done);
    int mrd_eff, n;
    clear_mon();
    wlmrd_cyc_i = VEC[i][0];
    wlo_cyc_i   = VEC[i][1];
    thresh      = int'(VEC[i][2]);
    gtap        = int'(VEC[i][3]);
    @(negedge clk_i); #1;
    start_i = 1'b1;
    @(negedge clk_i); #1;
    start_i = 1'b0;
    n = 0;
    while (!done_o && n < 20000) begin
      @(negedge clk_i); #1;
      n++;
      if (mid_start && n == 12) start_i = 1'b1;
      if (mid_start && n == 13) start_i = 1'b0;
    end
    if (start_at_done) start_i = 1'b1;
    mrd_eff = (VEC[i][0] == 0) ? 1 : int'(VEC[i][0]);
    check(done_o == 1'b1, $sformatf("R8 done seen v%0d", i), done_o, 1);
    check(int'(tap_o) == int'(VEC[i][4]), $sformatf("R3/R5/R6 tap v%0d", i), tap_o, VEC[i][4]);
    check(fail_o == VEC[i][5][0], $sformatf("R6/R7 fail v%0d", i), fail_o, VEC[i][5]);
    check(strobe_cnt == int'(VEC[i][4]) + 1, $sformatf("R5 trials v%0d", i), strobe_cnt, VEC[i][4] + 1);
    check(first_strobe_cyc - enter_ack_cyc == mrd_eff + 1, $sformatf("R2 gap v%0d", i),
          first_strobe_cyc - enter_ack_cyc, mrd_eff + 1);
    check(seq_err == 0, $sformatf("R4 tap order v%0d", i), seq_err, 0);
    check(early_err == 0, $sformatf("R1 strobe before enter ack v%0d", i), early_err, 0);
    check(exit_ack_cyc > first_strobe_cyc && done_cyc == exit_ack_cyc + 1,
          $sformatf("R8 exit then done v%0d", i), done_cyc, exit_ack_cyc + 1);
    @(negedge clk_i); #1;
    start_i = 1'b0;
    check(done_o == 1'b0, $sformatf("R8 done width v%0d", i), done_o, 0);
    repeat (6) @(negedge clk_i);
    #1;
    check(enter_reqs == 1, $sformatf("R9 single enter request v%0d", i), enter_reqs, 1);
    check(int'(tap_o) == int'(VEC[i][4]), $sformatf("R6 tap held v%0d", i), tap_o, VEC[i][4]);
  endtask

  initial begin
    clear_mon();
    repeat (3) @(negedge clk_i);
    #1;
    check(!mrw_req_o && !strobe_o && !done_o && !fail_o && tap_o == 0,
          "R10 reset outputs", {mrw_req_o, strobe_o, done_o, fail_o}, 0);
    rst_ni = 1'b1;
    // Directed corners interleaved with the table walk
    for (int i = 0; i < NVEC; i++) begin
      run_vec(i, (i == 2), (i == 3));
    end
    // R7: a fresh start after a failed search clears the flag (vector 4 ran after 3)
    run_vec(3, 1'b0, 1'b0);
    run_vec(1, 1'b0, 1'b0);
    check(fail_o == 1'b0, "R7 fail cleared by new start", fail_o, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule